// File: doc/BRIEF.md
# Cache Line Controller

This block is the lookup and update engine of a configurable cache. A CPU-side reference carries an access kind (data read, data write or instruction fetch) and a byte address. The controller cuts the address into block offset, set index and tag, compares the tag against every way of the selected set in one cycle, and reports hit or miss together with the way involved. On a miss it picks a way to replace, writes that way's block back to main memory first if it holds modified data, and then requests the new block from memory. The tag store keeps a valid flag, a modified flag, a stamp and a tag for every line. It keeps no data bytes.

Geometry and policies are elaboration parameters. `ASSOC` = 1 gives a direct-mapped cache, `ASSOC` = 0 a fully associative one, and any other power of two a set-associative one. The replacement choice is least recently used, oldest fill first, or pseudo-random. Writes either stay in the cache (copy-back) or go straight to memory (write-through). Write misses either allocate a line or bypass the cache. Two kinds of configuration stop elaboration: copy-back combined with bypassing write misses, and cache or block sizes that are not powers of two or where the block is not smaller than the cache. A nonzero `FLUSH_CNT` invalidates every line after each run of that many completed references. A flush drops lines without writing them back, which models a context switch.

The memory port uses a request/acknowledge handshake. `busy` stays high from the lookup cycle until the last memory operation of the reference has been acknowledged. No reference is taken while `busy` is high.

Top module: `cache_ctrl`

## Requirements
- R1: A reference is taken in a cycle where `req_valid` is high and `busy` is low. `resp_valid` is high for exactly the following cycle. `resp_hit` is 1 when a valid way of the addressed set holds the reference's tag, so any byte of a resident block hits.
- R2: `busy` is low when idle and after reset. It is high from the lookup cycle until the final memory acknowledge of the reference. While `mem_req` is high without `mem_ack`, `mem_op` and `mem_addr` hold their values. `mem_op` encodes 0 as block fill, 1 as block write-back and 2 as single write-through.
- R3: On a miss with at least one invalid way in the set, the lowest-numbered invalid way is filled and reported on `resp_way`.
- R4: With least-recently-used replacement and a full set, the way whose last hit or fill is oldest is replaced.
- R5: With oldest-fill replacement, hits do not refresh a line's age, so the way filled earliest is replaced even if it was just hit.
- R6: With random replacement, the victim comes from a pseudo-random register that advances once per miss, so successive victims in a full set vary.
- R7: In copy-back mode a write issues no memory operation. Replacing a modified line issues a write-back (`mem_op` 1) of that line's block address before the fill of the new block.
- R8: In write-through mode every write, hit or miss, issues one write-through (`mem_op` 2) carrying the full byte address, and no write-back ever occurs.
- R9: With write-allocate off, a write miss installs nothing, so a later read of that block misses.
- R10: With `FLUSH_CNT` = N > 0, all lines become invalid after every N-th completed reference, and only then.
- R11: A direct-mapped cache evicts a resident block when another block with the same index is fetched. A fully associative cache holds as many blocks as it has lines, whatever their addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | CPU reference present |
| req_type | input | 2 | 0 data read, 1 data write, 2 instruction fetch |
| req_addr | input | ADDR_W | Byte address of the reference |
| busy | output | 1 | Lookup or memory traffic in progress; no reference accepted |
| resp_valid | output | 1 | Lookup result valid this cycle |
| resp_hit | output | 1 | Reference hit |
| resp_way | output | WAY_W | Hit way, or the chosen victim on a miss |
| mem_req | output | 1 | Memory operation requested |
| mem_op | output | 2 | 0 fill, 1 write-back, 2 write-through |
| mem_addr | output | ADDR_W | Block address (fill, write-back) or byte address (write-through) |
| mem_ack | input | 1 | Memory operation complete |

## Verification
Four instances with different policies are driven with address sequences that fill a set and then force a replacement. One sequence hits an older line just before the replacement. A controller that ignored the hit would evict the wrong way under least-recently-used replacement. A controller that let the hit count under oldest-fill replacement would keep the way it should drop. A modified line is made the least recently used one, which shows whether the write-back is dropped or whether a clean line is also written back. Write misses without allocation are read back to expose a wrongly installed line. The flush counter is checked on both sides of its boundary, so an off-by-one flush shows up as a hit or miss in the wrong place.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {MEM_FILL = 2'd0, MEM_WBACK = 2'd1, MEM_WTHRU = 2'd2} memop_e;
  typedef enum logic [1:0] {REPL_LRU = 2'd0, REPL_FIFO = 2'd1, REPL_RAND = 2'd2} repl_e;
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_WBACK, ST_FILL, ST_WTHRU} state_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 3,
  parameter int IDX_BITS = 2,
  parameter int IDX_W    = 2,
  parameter int TAG_W    = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx
);
  assign tag = addr[ADDR_W-1 -: TAG_W];
  if (IDX_BITS == 0) begin : g_one_set
    assign idx = '0;
  end else begin : g_sets
    assign idx = addr[OFF_W +: IDX_BITS];
  end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick import cache_pkg::*; #(
  parameter int    WAYS  = 2,
  parameter int    WAY_W = 1,
  parameter int    TS_W  = 8,
  parameter repl_e REPL  = REPL_LRU
) (
  input  logic [WAYS-1:0]           valid,
  input  logic [WAYS-1:0][TS_W-1:0] stamp,
  input  logic [TS_W-1:0]           now,
  input  logic [WAY_W-1:0]          rnd,
  output logic [WAY_W-1:0]          victim
);
  logic [TS_W-1:0] best_age;
  logic [TS_W-1:0] age;

  always_comb begin
    victim   = '0;
    best_age = '0;
    age      = '0;
    // oldest stamp wins; modular age survives stamp counter wrap
    for (int w = 0; w < WAYS; w++) begin
      age = now - stamp[w];
      if (w == 0 || age > best_age) begin
        best_age = age;
        victim   = WAY_W'(w);
      end
    end
    if (REPL == REPL_RAND && WAYS > 1) victim = rnd;
    // a free way always takes precedence, lowest index first
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_flush_timer.sv
module cache_flush_timer #(
  parameter int FLUSH_CNT = 0,
  localparam int CNT_W = $clog2(FLUSH_CNT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic flush
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (FLUSH_CNT != 0) && (cnt_q == CNT_W'(FLUSH_CNT - 1));
  assign flush   = done && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (flush)     cnt_d = '0;
    else if (done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  if (FLUSH_CNT > 0) begin : g_chk
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(FLUSH_CNT));
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl import cache_pkg::*; #(
  parameter int    ADDR_W      = 16,
  parameter int    CACHE_BYTES = 64,
  parameter int    LINE_BYTES  = 8,
  parameter int    ASSOC       = 2,
  parameter repl_e REPL        = REPL_LRU,
  parameter bit    COPY_BACK   = 1'b1,
  parameter bit    WRITE_ALLOC = 1'b1,
  parameter int    FLUSH_CNT   = 0,
  parameter int    TS_W        = 8,
  localparam int   LINES       = CACHE_BYTES / LINE_BYTES,
  localparam int   WAYS        = (ASSOC == 0) ? LINES : ASSOC,
  localparam int   WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack
);
  localparam int SETS     = LINES / WAYS;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;
  localparam int LFSR_W   = 8;

  // configuration legality
  if (COPY_BACK && !WRITE_ALLOC) begin : g_bad_policy
    $error("copy-back requires write-allocate");
  end
  if ((CACHE_BYTES & (CACHE_BYTES - 1)) != 0 || (LINE_BYTES & (LINE_BYTES - 1)) != 0 ||
      LINE_BYTES >= CACHE_BYTES || (ASSOC != 0 && (ASSOC & (ASSOC - 1)) != 0) ||
      WAYS > LINES) begin : g_bad_geometry
    $error("illegal cache geometry");
  end

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_m} <= 2'b00;
    else        {rst_q, rst_m} <= {rst_m, 1'b1};
  end

  // control state and captured reference
  state_e            state_q, state_d;
  logic [1:0]        q_type;
  logic [ADDR_W-1:0] q_addr;
  logic [WAY_W-1:0]  vic_q;
  logic [TS_W-1:0]   now_q;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              accept, is_wr, done, flush;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign is_wr  = (q_type == ACC_WRITE);

  logic [TAG_W-1:0] q_tag;
  logic [IDX_W-1:0] q_idx;

  cache_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_BITS(IDX_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .addr(q_addr), .tag(q_tag), .idx(q_idx)
  );

  // tag store
  logic [WAYS-1:0] v_r [SETS];
  logic [WAYS-1:0] d_r [SETS];
  logic [TAG_W-1:0] tag_r [SETS][WAYS];
  logic [TS_W-1:0]  ts_r  [SETS][WAYS];

  logic [WAYS-1:0]           set_v, set_d, hit_vec;
  logic [WAYS-1:0][TS_W-1:0] set_ts;
  logic                      hit_any;
  logic [WAY_W-1:0]          hit_way, vic_way;

  assign set_v = v_r[q_idx];
  assign set_d = d_r[q_idx];

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      set_ts[w]  = ts_r[q_idx][w];
      hit_vec[w] = set_v[w] && (tag_r[q_idx][w] == q_tag);
      if (hit_vec[w]) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  cache_victim_pick #(
    .WAYS(WAYS), .WAY_W(WAY_W), .TS_W(TS_W), .REPL(REPL)
  ) u_pick (
    .valid(set_v), .stamp(set_ts), .now(now_q), .rnd(lfsr_q[WAY_W-1:0]), .victim(vic_way)
  );

  cache_flush_timer #(.FLUSH_CNT(FLUSH_CNT)) u_flush (
    .clk(clk), .rst_n(rst_q), .done(done), .flush(flush)
  );

  // next state
  logic look, miss;
  assign look = (state_q == ST_LOOK);
  assign miss = look && !hit_any;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_LOOK;
      ST_LOOK: begin
        if (hit_any)                             state_d = (is_wr && !COPY_BACK) ? ST_WTHRU : ST_IDLE;
        else if (is_wr && !WRITE_ALLOC)          state_d = ST_WTHRU;
        else if (set_v[vic_way] && set_d[vic_way]) state_d = ST_WBACK;
        else                                     state_d = ST_FILL;
      end
      ST_WBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL:  if (mem_ack) state_d = (is_wr && !COPY_BACK) ? ST_WTHRU : ST_IDLE;
      ST_WTHRU: if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign done = (state_q != ST_IDLE) && (state_d == ST_IDLE);

  // random source: x^8+x^6+x^5+x^4+1, one step per miss
  always_comb begin
    lfsr_d = lfsr_q;
    if (miss) lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
  end

  logic fill_ack, touch, set_dirty, fill_dirty;
  assign fill_ack   = (state_q == ST_FILL) && mem_ack;
  assign touch      = look && hit_any && (REPL != REPL_FIFO);
  assign set_dirty  = look && hit_any && is_wr && COPY_BACK;
  assign fill_dirty = is_wr && COPY_BACK;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      now_q   <= '0;
      lfsr_q  <= LFSR_W'(1);
    end else begin
      state_q <= state_d;
      lfsr_q  <= lfsr_d;
      if (accept) now_q <= now_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q_type <= req_type;
      q_addr <= req_addr;
    end
    if (look) vic_q <= vic_way;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int s = 0; s < SETS; s++) begin
        v_r[s] <= '0;
        d_r[s] <= '0;
      end
    end else begin
      if (set_dirty) d_r[q_idx][hit_way] <= 1'b1;
      if (fill_ack) begin
        v_r[q_idx][vic_q] <= 1'b1;
        d_r[q_idx][vic_q] <= fill_dirty;
      end
      if (flush) begin
        for (int s = 0; s < SETS; s++) begin
          v_r[s] <= '0;
          d_r[s] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (touch) ts_r[q_idx][hit_way] <= now_q;
    if (fill_ack) begin
      tag_r[q_idx][vic_q] <= q_tag;
      ts_r[q_idx][vic_q]  <= now_q;
    end
  end

  // outputs
  logic [ADDR_W-1:0] wb_addr, fill_addr;
  assign wb_addr   = (ADDR_W'(tag_r[q_idx][vic_q]) << (OFF_W + IDX_BITS)) |
                     (ADDR_W'(q_idx) << OFF_W);
  assign fill_addr = (ADDR_W'(q_tag) << (OFF_W + IDX_BITS)) | (ADDR_W'(q_idx) << OFF_W);

  assign busy       = (state_q != ST_IDLE);
  assign resp_valid = look;
  assign resp_hit   = look && hit_any;
  assign resp_way   = !look ? '0 : (hit_any ? hit_way : vic_way);

  always_comb begin
    mem_req  = 1'b0;
    mem_op   = MEM_FILL;
    mem_addr = '0;
    case (state_q)
      ST_WBACK: begin mem_req = 1'b1; mem_op = MEM_WBACK; mem_addr = wb_addr;   end
      ST_FILL:  begin mem_req = 1'b1; mem_op = MEM_FILL;  mem_addr = fill_addr; end
      ST_WTHRU: begin mem_req = 1'b1; mem_op = MEM_WTHRU; mem_addr = q_addr;    end
      default: ;
    endcase
  end

  // assertions
  p_resp_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_q)
    resp_valid |-> ($past(req_valid) && !$past(busy)));

  p_mem_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |-> busy);

  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));

  p_free_way_first_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (resp_valid && !resp_hit && !(&set_v)) |-> !set_v[resp_way]);

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && mem_op == MEM_WBACK && mem_ack) |=> (mem_req && mem_op == MEM_FILL));

  if (!COPY_BACK) begin : g_wt_chk
    p_no_wback_r8: assert property (@(posedge clk) disable iff (!rst_q)
      mem_req |-> (mem_op != MEM_WBACK));
  end
endmodule

// File: tb/test_cache_ctrl.sv
module mem_stub (
  input  logic        clk,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic [15:0] addr,
  output logic        ack
);
  int          n_fill, n_wb, n_wt;
  logic [15:0] last_wb, last_wt, last_fill;

  initial begin
    ack = 1'b0; n_fill = 0; n_wb = 0; n_wt = 0;
    last_wb = '0; last_wt = '0; last_fill = '0;
  end

  always @(negedge clk) begin
    if (req && !ack) begin
      ack <= 1'b1;
      case (op)
        2'd0: begin n_fill <= n_fill + 1; last_fill <= addr; end
        2'd1: begin n_wb   <= n_wb + 1;   last_wb   <= addr; end
        default: begin n_wt <= n_wt + 1;  last_wt   <= addr; end
      endcase
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

module test_cache_ctrl;
  import cache_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        req_valid [4];
  logic [1:0]  req_type  [4];
  logic [15:0] req_addr  [4];
  logic        busy [4], resp_valid [4], resp_hit [4];
  logic        mem_req [4], mem_ack [4];
  logic [1:0]  mem_op [4];
  logic [15:0] mem_addr [4];
  logic [0:0]  way_a, way_d;
  logic [2:0]  way_b;
  logic [1:0]  way_c;

  int checks = 0;
  int errors = 0;

  // A: 2-way, LRU, copy-back
  cache_ctrl i_cache_ctrl (
    .clk, .rst_n, .req_valid(req_valid[0]), .req_type(req_type[0]), .req_addr(req_addr[0]),
    .busy(busy[0]), .resp_valid(resp_valid[0]), .resp_hit(resp_hit[0]), .resp_way(way_a),
    .mem_req(mem_req[0]), .mem_op(mem_op[0]), .mem_addr(mem_addr[0]), .mem_ack(mem_ack[0]));
  // B: fully associative, oldest-fill, write-through, no allocate
  cache_ctrl #(.ASSOC(0), .REPL(REPL_FIFO), .COPY_BACK(1'b0), .WRITE_ALLOC(1'b0)) i_cache_fifo (
    .clk, .rst_n, .req_valid(req_valid[1]), .req_type(req_type[1]), .req_addr(req_addr[1]),
    .busy(busy[1]), .resp_valid(resp_valid[1]), .resp_hit(resp_hit[1]), .resp_way(way_b),
    .mem_req(mem_req[1]), .mem_op(mem_op[1]), .mem_addr(mem_addr[1]), .mem_ack(mem_ack[1]));
  // C: 4-way, random
  cache_ctrl #(.ASSOC(4), .REPL(REPL_RAND)) i_cache_rand (
    .clk, .rst_n, .req_valid(req_valid[2]), .req_type(req_type[2]), .req_addr(req_addr[2]),
    .busy(busy[2]), .resp_valid(resp_valid[2]), .resp_hit(resp_hit[2]), .resp_way(way_c),
    .mem_req(mem_req[2]), .mem_op(mem_op[2]), .mem_addr(mem_addr[2]), .mem_ack(mem_ack[2]));
  // D: direct-mapped, flush every 3 references
  cache_ctrl #(.ASSOC(1), .FLUSH_CNT(3)) i_cache_dm (
    .clk, .rst_n, .req_valid(req_valid[3]), .req_type(req_type[3]), .req_addr(req_addr[3]),
    .busy(busy[3]), .resp_valid(resp_valid[3]), .resp_hit(resp_hit[3]), .resp_way(way_d),
    .mem_req(mem_req[3]), .mem_op(mem_op[3]), .mem_addr(mem_addr[3]), .mem_ack(mem_ack[3]));

  mem_stub m0 (.clk, .req(mem_req[0]), .op(mem_op[0]), .addr(mem_addr[0]), .ack(mem_ack[0]));
  mem_stub m1 (.clk, .req(mem_req[1]), .op(mem_op[1]), .addr(mem_addr[1]), .ack(mem_ack[1]));
  mem_stub m2 (.clk, .req(mem_req[2]), .op(mem_op[2]), .addr(mem_addr[2]), .ack(mem_ack[2]));
  mem_stub m3 (.clk, .req(mem_req[3]), .op(mem_op[3]), .addr(mem_addr[3]), .ack(mem_ack[3]));

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, IF = 2'd2;

  function automatic int way_of(int k);
    case (k)
      0: return int'(way_a);
      1: return int'(way_b);
      2: return int'(way_c);
      default: return int'(way_d);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(int k, logic [1:0] t, logic [15:0] a, output int hit, output int way);
    @(negedge clk);
    while (busy[k]) @(negedge clk);
    req_valid[k] = 1'b1; req_type[k] = t; req_addr[k] = a;
    @(negedge clk);
    req_valid[k] = 1'b0;
    if (!resp_valid[k]) begin
      errors++;
      $display("FAIL R1: actual resp_valid 0 expected 1 (inst %0d addr %h)", k, a);
    end
    hit = int'(resp_hit[k]);
    way = way_of(k);
    while (busy[k]) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      check("R2 busy after reset", int'(busy[k]), 0);
      check("R2 mem_req after reset", int'(mem_req[k]), 0);
    end
  endtask

  task automatic t_lru();
    int h, w;
    access(0, RD, 16'h0000, h, w); check("R3 first miss", h, 0); check("R3 way0", w, 0);
    check("R2 one fill", m0.n_fill, 1); check("R2 fill addr", int'(m0.last_fill), 0);
    access(0, RD, 16'h0004, h, w); check("R1 same block hit", h, 1);
    access(0, IF, 16'h0020, h, w); check("R3 second way", w, 1);
    access(0, RD, 16'h0000, h, w); check("R4 refresh hit", h, 1);
    access(0, RD, 16'h0040, h, w); check("R4 lru victim", w, 1);
    access(0, RD, 16'h0000, h, w); check("R4 kept line", h, 1);
    access(0, RD, 16'h0020, h, w); check("R4 evicted line", h, 0);
  endtask

  task automatic t_copy_back();
    int h, w, wt0, wb0;
    wt0 = m0.n_wt; wb0 = m0.n_wb;
    access(0, WR, 16'h0008, h, w); check("R7 write miss", h, 0);
    access(0, WR, 16'h000C, h, w); check("R7 write hit", h, 1);
    check("R7 no write-through", m0.n_wt - wt0, 0);
    access(0, RD, 16'h0028, h, w);
    access(0, RD, 16'h000C, h, w); check("R7 dirty line hit", h, 1);
    access(0, RD, 16'h0048, h, w); check("R7 clean victim", m0.n_wb - wb0, 0);
    access(0, RD, 16'h0028, h, w); check("R7 dirty victim way", w, 0);
    check("R7 one write-back", m0.n_wb - wb0, 1);
    check("R7 write-back addr", int'(m0.last_wb), 16'h0008);
  endtask

  task automatic t_write_through();
    int h, w;
    access(1, WR, 16'h0100, h, w); check("R9 write miss", h, 0);
    check("R9 no fill", m1.n_fill, 0);
    check("R8 wt count", m1.n_wt, 1); check("R8 wt addr", int'(m1.last_wt), 16'h0100);
    access(1, RD, 16'h0100, h, w); check("R9 not installed", h, 0);
    access(1, WR, 16'h0104, h, w); check("R8 write hit", h, 1);
    check("R8 wt on hit", m1.n_wt, 2); check("R8 wt hit addr", int'(m1.last_wt), 16'h0104);
  endtask

  task automatic t_fifo();
    int h, w;
    for (int i = 0; i < 7; i++) begin
      access(1, RD, 16'(i * 8), h, w); check("R11 fully assoc fill way", w, i + 1);
    end
    access(1, RD, 16'h0100, h, w); check("R5 oldest hit", h, 1);
    access(1, RD, 16'h0200, h, w); check("R5 oldest fill evicted", w, 0);
    access(1, RD, 16'h0100, h, w); check("R5 evicted miss", h, 0);
    access(1, RD, 16'h0008, h, w); check("R11 fully assoc resident", h, 1);
    check("R8 no write-back", m1.n_wb, 0);
  endtask

  task automatic t_random();
    int h, w, first, differ;
    for (int i = 0; i < 4; i++) begin
      access(2, RD, 16'(i * 16), h, w); check("R3 free way order", w, i);
    end
    differ = 0; first = -1;
    for (int i = 4; i < 10; i++) begin
      access(2, RD, 16'(i * 16), h, w); check("R6 full set miss", h, 0);
      if (first < 0) first = w; else if (w != first) differ = 1;
    end
    check("R6 victims vary", differ, 1);
  endtask

  task automatic t_flush();
    int h, w;
    access(3, RD, 16'h0000, h, w); check("R10 cold miss", h, 0);
    access(3, RD, 16'h0000, h, w); check("R10 hit before flush", h, 1);
    access(3, RD, 16'h0004, h, w); check("R10 third ref hit", h, 1);
    access(3, RD, 16'h0000, h, w); check("R10 miss after flush", h, 0);
    access(3, RD, 16'h0040, h, w); check("R11 conflict miss", h, 0); check("R11 dm way", w, 0);
    access(3, RD, 16'h0000, h, w); check("R11 conflict evicted", h, 0);
    access(3, RD, 16'h0000, h, w); check("R10 miss after second flush", h, 0);
    access(3, RD, 16'h0000, h, w); check("R10 no early flush", h, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      req_valid[k] = 1'b0; req_type[k] = RD; req_addr[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lru();
    t_copy_back();
    t_write_through();
    t_fifo();
    t_random();
    t_flush();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule